// File: doc/BRIEF.md
# ECC-Based DIMM Half Resolver

When a memory error lands on a chip-select, that chip-select may be backed by one DIMM or by a pair of DIMMs. A pair is a low slot and a high slot that together form a 128-bit wide access. This block takes the facts that are already known about the error and names the DIMM, or DIMMs, that hold it. Those facts are:

- which of the two slots are populated;
- the ECC scheme in force;
- the address bit that selects the 64-bit half, and the lowest address bit that can be trusted;
- whether the syndrome was correctable;
- for symbol-based ECC, the fields of the decoded symbol.

Syndrome decoding happens upstream. The symbol's type, its highest bit position and a flag for an unrecognised symbol arrive as plain inputs.

With per-half 64/8 ECC, each 64-bit half is checked on its own. The half is therefore known even for uncorrectable errors, provided the address is resolved finely enough. With symbol-based ECC, only a correctable error points at a symbol, and so at a half. An uncorrectable symbol-mode error implicates both DIMMs.

Each cycle with `req_valid` high produces one registered result code, one clock later, together with `rsp_valid`. The code holds while no request arrives.

Top module: `dimm_half_resolver`

## Requirements
- R1: With neither slot populated, the result code is 3'b100 (no DIMM).
- R2: With exactly one slot populated, either one, the result code is 3'b001 (low DIMM). This holds whatever the ECC mode and error fields are.
- R3: With both slots populated, `ecc_mode_sym`=0 (64/8 mode) and `lsb_valid` greater than SPLIT_BIT (default 3), the result code is 3'b101 (insufficient resolution).
- R4: With both slots populated, 64/8 mode and `lsb_valid` <= SPLIT_BIT, `err_addr_half`=1 gives 3'b010 (high DIMM) and 0 gives 3'b001 (low DIMM). The `correctable` flag does not change this.
- R5: With both slots populated, `ecc_mode_sym`=1 (symbol mode), a correctable error and a recognised symbol, the result depends on the symbol type. A data symbol (`sym_is_check`=0) with `sym_hi_bit` <= 63 gives 3'b001. A check symbol (`sym_is_check`=1) with `sym_hi_bit` <= 7 gives 3'b001. Any other such symbol gives 3'b010.
- R6: With both slots populated, symbol mode and `correctable`=0, the result code is 3'b011 (both DIMMs). This holds regardless of the symbol fields.
- R7: With both slots populated, symbol mode, a correctable error and `sym_bad`=1, the result code is 3'b110 (syndrome invalid).
- R8: `rsp_valid` is high in exactly the cycles that follow a cycle with `req_valid` high. `rsp_code` in that cycle reflects the inputs sampled with the request.
- R9: A cycle with `req_valid` low leaves `rsp_code` unchanged, whatever the other inputs are.
- R10: While `rst_n` is low, `rsp_valid` is 0 and `rsp_code` is 3'b000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | A resolution request is present this cycle |
| slot_lo_ok | input | 1 | Low (first) DIMM slot of the chip-select is populated |
| slot_hi_ok | input | 1 | High (second) DIMM slot of the chip-select is populated |
| ecc_mode_sym | input | 1 | 0: per-half 64/8 ECC, 1: symbol-based ECC |
| err_addr_half | input | 1 | Error address bit at position SPLIT_BIT (selects the 64-bit half) |
| lsb_valid | input | LSB_W | Lowest error address bit that is valid |
| correctable | input | 1 | Syndrome was correctable |
| sym_bad | input | 1 | Decoded symbol was not recognised |
| sym_is_check | input | 1 | Decoded symbol covers check bits (1) or data bits (0) |
| sym_hi_bit | input | HIBIT_W | Highest bit position covered by the decoded symbol |
| rsp_valid | output | 1 | Result code is fresh this cycle |
| rsp_code | output | 3 | Result code |

## Verification
The assertions relate each registered code to the inputs sampled on the previous edge. They assume that those inputs are stable and known at the edge whenever `req_valid` is high. They also assume `rst_n` is the only source of disruption.

The stimulus changes every input only on the falling edge. It sweeps every slot combination, both modes, both half-select values and the threshold values on each side of the comparisons. It then follows each request with an idle cycle in which every other input is inverted. This confirms that idle cycles leave the held code untouched.

// File: rtl/dimm_res_pkg.sv
package dimm_res_pkg;

    typedef enum logic [2:0] {
        RC_IDLE   = 3'b000,
        RC_LOW    = 3'b001,
        RC_HIGH   = 3'b010,
        RC_BOTH   = 3'b011,
        RC_NODIMM = 3'b100,
        RC_NORES  = 3'b101,
        RC_BADSYM = 3'b110
    } rcode_e;

    typedef enum logic [1:0] {
        POP_NONE = 2'd0,
        POP_ONE  = 2'd1,
        POP_TWO  = 2'd2
    } pop_e;

    typedef struct packed {
        logic   vld;
        rcode_e code;
    } rsp_s;

endpackage

// File: rtl/dimm_res_pop.sv
module dimm_res_pop
    import dimm_res_pkg::*;
(
    input  logic slot_lo_ok,
    input  logic slot_hi_ok,
    output pop_e pop
);
    always_comb begin
        case ({slot_hi_ok, slot_lo_ok})
            2'b00:   pop = POP_NONE;
            2'b11:   pop = POP_TWO;
            default: pop = POP_ONE;
        endcase
    end
endmodule

// File: rtl/dimm_res_split.sv
module dimm_res_split
    import dimm_res_pkg::*;
#(
    parameter int LSB_W     = 6,
    parameter int SPLIT_BIT = 3
) (
    input  logic [LSB_W-1:0] lsb_valid,
    input  logic             err_addr_half,
    output rcode_e           code
);
    localparam logic [LSB_W-1:0] SPLIT_LIM = LSB_W'(SPLIT_BIT);

    always_comb begin
        if (lsb_valid > SPLIT_LIM) begin
            code = RC_NORES;
        end else if (err_addr_half) begin
            code = RC_HIGH;
        end else begin
            code = RC_LOW;
        end
    end
endmodule

// File: rtl/dimm_res_symbol.sv
module dimm_res_symbol
    import dimm_res_pkg::*;
#(
    parameter int HIBIT_W   = 7,
    parameter int DATA_TOP  = 63,
    parameter int CHECK_TOP = 7
) (
    input  logic               correctable,
    input  logic               sym_bad,
    input  logic               sym_is_check,
    input  logic [HIBIT_W-1:0] sym_hi_bit,
    output rcode_e             code
);
    localparam logic [HIBIT_W-1:0] DATA_LIM  = HIBIT_W'(DATA_TOP);
    localparam logic [HIBIT_W-1:0] CHECK_LIM = HIBIT_W'(CHECK_TOP);

    logic in_low_half;

    always_comb begin
        in_low_half = sym_is_check ? (sym_hi_bit <= CHECK_LIM)
                                   : (sym_hi_bit <= DATA_LIM);
        if (!correctable) begin
            code = RC_BOTH;
        end else if (sym_bad) begin
            code = RC_BADSYM;
        end else if (in_low_half) begin
            code = RC_LOW;
        end else begin
            code = RC_HIGH;
        end
    end
endmodule

// File: rtl/dimm_half_resolver.sv
module dimm_half_resolver
    import dimm_res_pkg::*;
#(
    parameter int LSB_W     = 6,
    parameter int SPLIT_BIT = 3,
    parameter int HIBIT_W   = 7,
    parameter int DATA_TOP  = 63,
    parameter int CHECK_TOP = 7
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic               slot_lo_ok,
    input  logic               slot_hi_ok,
    input  logic               ecc_mode_sym,
    input  logic               err_addr_half,
    input  logic [LSB_W-1:0]   lsb_valid,
    input  logic               correctable,
    input  logic               sym_bad,
    input  logic               sym_is_check,
    input  logic [HIBIT_W-1:0] sym_hi_bit,
    output logic               rsp_valid,
    output logic [2:0]         rsp_code
);
    pop_e   pop;
    rcode_e code_split;
    rcode_e code_sym;
    rsp_s   state_d;
    rsp_s   state_q;

    dimm_res_pop u_pop (
        .slot_lo_ok (slot_lo_ok),
        .slot_hi_ok (slot_hi_ok),
        .pop        (pop)
    );

    dimm_res_split #(
        .LSB_W     (LSB_W),
        .SPLIT_BIT (SPLIT_BIT)
    ) u_split (
        .lsb_valid     (lsb_valid),
        .err_addr_half (err_addr_half),
        .code          (code_split)
    );

    dimm_res_symbol #(
        .HIBIT_W   (HIBIT_W),
        .DATA_TOP  (DATA_TOP),
        .CHECK_TOP (CHECK_TOP)
    ) u_sym (
        .correctable  (correctable),
        .sym_bad      (sym_bad),
        .sym_is_check (sym_is_check),
        .sym_hi_bit   (sym_hi_bit),
        .code         (code_sym)
    );

    always_comb begin
        state_d     = state_q;
        state_d.vld = req_valid;
        if (req_valid) begin
            case (pop)
                POP_NONE: state_d.code = RC_NODIMM;
                POP_ONE:  state_d.code = RC_LOW;
                default:  state_d.code = ecc_mode_sym ? code_sym : code_split;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '{vld: 1'b0, code: RC_IDLE};
        end else begin
            state_q <= state_d;
        end
    end

    assign rsp_valid = state_q.vld;
    assign rsp_code  = state_q.code;
endmodule

// File: rtl/dimm_res_checker.sv
module dimm_res_checker
    import dimm_res_pkg::*;
#(
    parameter int LSB_W     = 6,
    parameter int SPLIT_BIT = 3,
    parameter int HIBIT_W   = 7,
    parameter int DATA_TOP  = 63,
    parameter int CHECK_TOP = 7
) (
    input logic               clk,
    input logic               rst_n,
    input logic               req_valid,
    input logic               slot_lo_ok,
    input logic               slot_hi_ok,
    input logic               ecc_mode_sym,
    input logic               err_addr_half,
    input logic [LSB_W-1:0]   lsb_valid,
    input logic               correctable,
    input logic               sym_bad,
    input logic               sym_is_check,
    input logic [HIBIT_W-1:0] sym_hi_bit,
    input logic               rsp_valid,
    input logic [2:0]         rsp_code
);
    logic pair;
    assign pair = slot_lo_ok && slot_hi_ok;

    assert_no_dimm_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !slot_lo_ok && !slot_hi_ok) |=> (rsp_code == RC_NODIMM));

    assert_single_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && (slot_lo_ok != slot_hi_ok)) |=> (rsp_code == RC_LOW));

    assert_coarse_addr_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && pair && !ecc_mode_sym && (int'(lsb_valid) > SPLIT_BIT))
        |=> (rsp_code == RC_NORES));

    assert_half_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && pair && !ecc_mode_sym && (int'(lsb_valid) <= SPLIT_BIT) && err_addr_half)
        |=> (rsp_code == RC_HIGH));

    assert_half_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && pair && !ecc_mode_sym && (int'(lsb_valid) <= SPLIT_BIT) && !err_addr_half)
        |=> (rsp_code == RC_LOW));

    assert_sym_data_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && pair && ecc_mode_sym && correctable && !sym_bad && !sym_is_check
         && (int'(sym_hi_bit) <= DATA_TOP)) |=> (rsp_code == RC_LOW));

    assert_sym_check_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && pair && ecc_mode_sym && correctable && !sym_bad && sym_is_check
         && (int'(sym_hi_bit) > CHECK_TOP)) |=> (rsp_code == RC_HIGH));

    assert_uncorr_both_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && pair && ecc_mode_sym && !correctable) |=> (rsp_code == RC_BOTH));

    assert_bad_symbol_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && pair && ecc_mode_sym && correctable && sym_bad) |=> (rsp_code == RC_BADSYM));

    assert_strobe_on_R8: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    assert_strobe_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> $stable(rsp_code));
endmodule

bind dimm_half_resolver dimm_res_checker #(
    .LSB_W     (LSB_W),
    .SPLIT_BIT (SPLIT_BIT),
    .HIBIT_W   (HIBIT_W),
    .DATA_TOP  (DATA_TOP),
    .CHECK_TOP (CHECK_TOP)
) i_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .slot_lo_ok    (slot_lo_ok),
    .slot_hi_ok    (slot_hi_ok),
    .ecc_mode_sym  (ecc_mode_sym),
    .err_addr_half (err_addr_half),
    .lsb_valid     (lsb_valid),
    .correctable   (correctable),
    .sym_bad       (sym_bad),
    .sym_is_check  (sym_is_check),
    .sym_hi_bit    (sym_hi_bit),
    .rsp_valid     (rsp_valid),
    .rsp_code      (rsp_code)
);

// File: tb/test_dimm_half_resolver.sv
module test_dimm_half_resolver;
    localparam int LSB_W   = 6;
    localparam int HIBIT_W = 7;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               req_valid = 1'b0;
    logic               slot_lo_ok = 1'b0;
    logic               slot_hi_ok = 1'b0;
    logic               ecc_mode_sym = 1'b0;
    logic               err_addr_half = 1'b0;
    logic [LSB_W-1:0]   lsb_valid = '0;
    logic               correctable = 1'b0;
    logic               sym_bad = 1'b0;
    logic               sym_is_check = 1'b0;
    logic [HIBIT_W-1:0] sym_hi_bit = '0;
    logic               rsp_valid;
    logic [2:0]         rsp_code;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    dimm_half_resolver i_dimm_half_resolver (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_valid     (req_valid),
        .slot_lo_ok    (slot_lo_ok),
        .slot_hi_ok    (slot_hi_ok),
        .ecc_mode_sym  (ecc_mode_sym),
        .err_addr_half (err_addr_half),
        .lsb_valid     (lsb_valid),
        .correctable   (correctable),
        .sym_bad       (sym_bad),
        .sym_is_check  (sym_is_check),
        .sym_hi_bit    (sym_hi_bit),
        .rsp_valid     (rsp_valid),
        .rsp_code      (rsp_code)
    );

    task automatic check(input string req, input logic [2:0] act, input logic [2:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    function automatic logic [2:0] model(input bit lo, input bit hi, input bit sym,
                                         input bit half, input int lsb, input bit corr,
                                         input bit bad, input bit chk, input int hb);
        if (!lo && !hi) return 3'b100;
        if (lo != hi)   return 3'b001;
        if (!sym) begin
            if (lsb > 3) return 3'b101;
            return half ? 3'b010 : 3'b001;
        end
        if (!corr) return 3'b011;
        if (bad)   return 3'b110;
        if (chk)   return (hb <= 7)  ? 3'b001 : 3'b010;
        return (hb <= 63) ? 3'b001 : 3'b010;
    endfunction

    function automatic string tag(input bit lo, input bit hi, input bit sym,
                                  input int lsb, input bit corr, input bit bad);
        if (!lo && !hi) return "R1";
        if (lo != hi)   return "R2";
        if (!sym)       return (lsb > 3) ? "R3" : "R4";
        if (!corr)      return "R6";
        if (bad)        return "R7";
        return "R5";
    endfunction

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog: actual running expected finished");
            summary();
            $finish;
        end
    end

    initial begin
        int hbs[6]  = '{0, 7, 8, 63, 64, 127};
        int lsbs[4] = '{0, 3, 4, 39};
        logic [2:0] exp;
        repeat (3) @(posedge clk);
        #1;
        check("R10 reset valid", {2'b00, rsp_valid}, 3'b000);
        check("R10 reset code", rsp_code, 3'b000);
        @(negedge clk);
        rst_n = 1'b1;

        for (int p = 0; p < 4; p++)
        for (int m = 0; m < 2; m++)
        for (int h = 0; h < 2; h++)
        for (int l = 0; l < 4; l++)
        for (int c = 0; c < 2; c++)
        for (int b = 0; b < 2; b++)
        for (int k = 0; k < 2; k++)
        for (int s = 0; s < 6; s++) begin
            @(negedge clk);
            req_valid     = 1'b1;
            slot_lo_ok    = p[0];
            slot_hi_ok    = p[1];
            ecc_mode_sym  = m[0];
            err_addr_half = h[0];
            lsb_valid     = LSB_W'(lsbs[l]);
            correctable   = c[0];
            sym_bad       = b[0];
            sym_is_check  = k[0];
            sym_hi_bit    = HIBIT_W'(hbs[s]);
            exp = model(p[0], p[1], m[0], h[0], lsbs[l], c[0], b[0], k[0], hbs[s]);
            @(posedge clk);
            #1;
            check("R8 strobe set", {2'b00, rsp_valid}, 3'b001);
            check(tag(p[0], p[1], m[0], lsbs[l], c[0], b[0]), rsp_code, exp);
            // idle cycle with every other input inverted: R9 and R8
            @(negedge clk);
            req_valid     = 1'b0;
            slot_lo_ok    = ~slot_lo_ok;
            slot_hi_ok    = ~slot_hi_ok;
            ecc_mode_sym  = ~ecc_mode_sym;
            err_addr_half = ~err_addr_half;
            lsb_valid     = ~lsb_valid;
            correctable   = ~correctable;
            sym_bad       = ~sym_bad;
            sym_is_check  = ~sym_is_check;
            sym_hi_bit    = ~sym_hi_bit;
            @(posedge clk);
            #1;
            check("R8 strobe clear", {2'b00, rsp_valid}, 3'b000);
            check("R9 idle hold", rsp_code, exp);
        end

        done = 1'b1;
        summary();
        $finish;
    end
endmodule